// File: doc/BRIEF.md
# Accumulator machine instruction-cycle sequencer

This block is the control unit of a 16-bit, single-accumulator machine. A step counter, reset to zero at the start of every instruction, walks through one-clock micro-steps. The counter value is decoded into one-hot timing lines. The three opcode bits of the fetched word are decoded into eight instruction lines. Together these lines drive the program counter, address register, instruction register and data register. They also raise read and write strobes toward a single-port synchronous memory of 4096 words, which returns read data one clock after the strobe.

Instruction words carry the mode flag in bit 15 (1 = the address field points at a pointer word), the opcode in bits 14..12 and a 12-bit address in bits 11..0. Steps 0 to 2 are shared by every instruction: fetch address, fetch word, decode. Opcodes 0 to 6 are memory-reference operations with their own step counts: AND, ADD, load, store, jump, call-and-save, and increment-and-skip-if-zero. Indirect mode inserts two extra steps to pick up the pointer. Opcode 7 is not executed here. At step 3 the block pulses a handoff strobe carrying the mode bit and starts the next fetch. The accumulator itself lives outside. The block sees its value on an input and requests updates through a write strobe and an operation code, with the operand presented on the memory read-data bus.

Top module: `acs_ctrl`

## Requirements
- R1: Under reset, PC, AR, IR, DR and the step counter all read zero.
- R2: In step 0 the block reads memory at PC (mem_addr_o equals PC, mem_rd_o high) and AR takes PC.
- R3: In step 1 IR takes the word returned by memory and PC increments by one, wrapping from 0xFFF to 0x000.
- R4: In step 2 AR takes IR bits 11..0, and the mode bit (IR bit 15) and opcode (IR bits 14..12) are latched for the rest of the instruction.
- R5: In indirect mode on opcodes 0 to 6, step 3 reads the pointer at AR and step 4 loads DR with it and AR with its bits 11..0, which becomes the effective address.
- R6: AND (0), ADD (1) and load (2) read the operand, then pulse acc_we_o with acc_op_o 00 for AND, 01 for ADD and 10 for load. The operand is on mem_rdata_i in that cycle. The instruction ends after 5 steps in direct mode and 7 in indirect mode.
- R7: Store (3) writes the accumulator to the effective address and ends after 4 steps (direct) or 6 steps (indirect).
- R8: Jump (4) loads PC with the effective address and ends after 4 or 6 steps.
- R9: Call-and-save (5) writes the incremented PC to the effective address, loads PC with the effective address plus one, and ends after 4 or 6 steps.
- R10: Increment-and-skip (6) reads the word, writes back the word plus one, and advances PC by one more if the written value is zero. DR holds the written value. It ends after 6 or 8 steps.
- R11: Opcode 7 pulses regop_o for exactly one cycle, in step 3, with regop_ind_o equal to the mode bit. It makes no memory access in that step and ends after 4 steps.
- R12: While halt_i is high, no register or the step counter changes, and no memory strobe, accumulator strobe or handoff strobe is raised. Execution resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Freezes the sequencer while high |
| acc_i | input | 16 | Current accumulator value |
| mem_rdata_i | input | 16 | Memory read data, valid one clock after mem_rd_o |
| mem_addr_o | output | 12 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Memory write data |
| acc_we_o | output | 1 | Accumulator update strobe |
| acc_op_o | output | 2 | Accumulator operation: 00 AND, 01 ADD, 10 load |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| ir_o | output | 16 | Instruction register |
| dr_o | output | 16 | Data register |
| step_o | output | 4 | Current micro-step number |
| regop_o | output | 1 | Handoff strobe for opcode 7 |
| regop_ind_o | output | 1 | Mode bit accompanying the handoff |

## Verification
The bench targets these corner cases:
- An increment-and-skip whose operand is 0xFFFF. A design that tested the word before the increment, or the wrong register, would fail to skip.
- Indirect pointers whose upper bits are set. A design that copied all 16 pointer bits, or used the pointer's own address, would touch the wrong word.
- PC wrapping at 0xFFF, and call-and-save writing PC after the fetch increment, not before it.
- Step counts per opcode and mode. A counter that cleared late or early would shift every following fetch.
- A halt held in the middle of an instruction. A design that let strobes or PC move while frozen would corrupt the operand or repeat a read.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam int OPC_AND = 0;
  localparam int OPC_ADD = 1;
  localparam int OPC_LDA = 2;
  localparam int OPC_STA = 3;
  localparam int OPC_BUN = 4;
  localparam int OPC_BSA = 5;
  localparam int OPC_ISZ = 6;
  localparam int OPC_REG = 7;

  typedef enum logic [1:0] {
    ACC_AND  = 2'd0,
    ACC_ADD  = 2'd1,
    ACC_LOAD = 2'd2
  } acc_op_e;
endpackage

// File: rtl/acs_onehot_dec.sv
module acs_onehot_dec #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign hot_o[g] = (code_i == IN_W'(g));
  end
endmodule

// File: rtl/acs_step_ctr.sv
module acs_step_ctr #(
  parameter int STEP_W = 4,
  localparam int STEP_N = 1 << STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [STEP_W-1:0] step_o,
  output logic [STEP_N-1:0] tick_o
);
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   step_q <= '0;
    else if (en_i) step_q <= clr_i ? '0 : step_q + STEP_W'(1);
  end

  acs_onehot_dec #(.IN_W(STEP_W)) u_tdec (
    .code_i (step_q),
    .hot_o  (tick_o)
  );

  assign step_o = step_q;
endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
  import acs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              acc_we_o,
  output logic [1:0]        acc_op_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [STEP_W-1:0] step_o,
  output logic              regop_o,
  output logic              regop_ind_o
);
  localparam int OPC_W  = DATA_W - ADDR_W - 1;
  localparam int OPC_N  = 1 << OPC_W;
  localparam int STEP_N = 1 << STEP_W;
  localparam int PAD_W  = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [DATA_W-1:0] ir_q, dr_q;
  logic              ind_q;
  logic [OPC_N-1:0]  opd_q, opd_dec;
  logic [STEP_N-1:0] tick;
  logic              tick_unused;
  logic              run, sc_clr;
  logic              fetch0, fetch1, dec2, ptr_rd, ptr_ld, ex0, ex1, ex2;
  logic              is_and, is_add, is_lda, is_sta, is_bun, is_bsa, is_isz;
  logic              is_reg, mem_ref, acc_kind;
  acc_op_e           acc_op;

  acs_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .clr_i  (sc_clr),
    .step_o (step_o),
    .tick_o (tick)
  );

  acs_onehot_dec #(.IN_W(OPC_W)) u_odec (
    .code_i (ir_q[DATA_W-2:ADDR_W]),
    .hot_o  (opd_dec)
  );

  assign tick_unused = |tick[STEP_N-1:8];

  assign run     = ~halt_i;
  assign is_and  = opd_q[OPC_AND];
  assign is_add  = opd_q[OPC_ADD];
  assign is_lda  = opd_q[OPC_LDA];
  assign is_sta  = opd_q[OPC_STA];
  assign is_bun  = opd_q[OPC_BUN];
  assign is_bsa  = opd_q[OPC_BSA];
  assign is_isz  = opd_q[OPC_ISZ];
  assign is_reg  = opd_q[OPC_REG];
  assign mem_ref = ~is_reg;
  assign acc_kind = is_and | is_add | is_lda;

  // shared steps, pointer pick-up, then execute steps offset by the mode
  assign fetch0 = tick[0];
  assign fetch1 = tick[1];
  assign dec2   = tick[2];
  assign ptr_rd = tick[3] & ind_q & mem_ref;
  assign ptr_ld = tick[4] & ind_q & mem_ref;
  assign ex0    = mem_ref & (ind_q ? tick[5] : tick[3]);
  assign ex1    = mem_ref & (ind_q ? tick[6] : tick[4]);
  assign ex2    = mem_ref & (ind_q ? tick[7] : tick[5]);

  assign sc_clr = (tick[3] & is_reg)
                | (ex0 & (is_sta | is_bun | is_bsa))
                | (ex1 & acc_kind)
                | (ex2 & is_isz);

  assign mem_rd_o    = run & (fetch0 | ptr_rd | (ex0 & (acc_kind | is_isz)));
  assign mem_wr_o    = run & ((ex0 & (is_sta | is_bsa)) | (ex2 & is_isz));
  assign mem_addr_o  = fetch0 ? pc_q : ar_q;
  assign mem_wdata_o = is_sta ? acc_i : (is_bsa ? {{PAD_W{1'b0}}, pc_q} : dr_q);

  always_comb begin
    acc_op = ACC_LOAD;
    if (is_and)      acc_op = ACC_AND;
    else if (is_add) acc_op = ACC_ADD;
  end

  assign acc_we_o    = run & ex1 & acc_kind;
  assign acc_op_o    = acc_op;
  assign regop_o     = run & tick[3] & is_reg;
  assign regop_ind_o = ind_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      dr_q  <= '0;
      ind_q <= 1'b0;
      opd_q <= '0;
    end else if (run) begin
      if (fetch0) ar_q <= pc_q;
      if (fetch1) begin
        ir_q <= mem_rdata_i;
        pc_q <= pc_q + ADDR_W'(1);
      end
      if (dec2) begin
        ar_q  <= ir_q[ADDR_W-1:0];
        ind_q <= ir_q[DATA_W-1];
        opd_q <= opd_dec;
      end
      if (ptr_ld) begin
        dr_q <= mem_rdata_i;
        ar_q <= mem_rdata_i[ADDR_W-1:0];
      end
      if (ex0 & is_sta) dr_q <= acc_i;
      if (ex0 & is_bun) pc_q <= ar_q;
      if (ex0 & is_bsa) pc_q <= ar_q + ADDR_W'(1);
      if (ex1 & acc_kind) dr_q <= mem_rdata_i;
      if (ex1 & is_isz)   dr_q <= mem_rdata_i + DATA_W'(1);
      if (ex2 & is_isz & (dr_q == '0)) pc_q <= pc_q + ADDR_W'(1);
    end
  end

  assign pc_o = pc_q;
  assign ar_o = ar_q;
  assign ir_o = ir_q;
  assign dr_o = dr_q;
endmodule

// File: rtl/acs_ctrl_chk.sv
module acs_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int STEP_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              acc_we_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] ar_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [STEP_W-1:0] step_o,
  input logic              regop_o
);
  AST_FETCH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == '0 && !halt_i) |-> (mem_rd_o && mem_addr_o == pc_o)); // R2
  AST_FETCH_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == '0 && !halt_i) |=> (ar_o == $past(pc_o))); // R2
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == STEP_W'(1) && !halt_i) |=>
      (pc_o == ADDR_W'($past(pc_o) + 1'b1) && ir_o == $past(mem_rdata_i))); // R3
  AST_DECODE_AR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == STEP_W'(2) && !halt_i) |=> (ar_o == $past(ir_o[ADDR_W-1:0]))); // R4
  AST_ACC_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |=> (step_o == '0)); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R7
  AST_REGOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regop_o |-> (step_o == STEP_W'(3) && !mem_rd_o && !mem_wr_o)); // R11
  AST_REGOP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regop_o |=> (step_o == '0 && !regop_o)); // R11
  AST_HALT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> (!mem_rd_o && !mem_wr_o && !acc_we_o && !regop_o)); // R12
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> ($stable(step_o) && $stable(pc_o) && $stable(ar_o) && $stable(ir_o))); // R12
endmodule

bind acs_ctrl acs_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .mem_rdata_i (mem_rdata_i),
  .mem_addr_o  (mem_addr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .acc_we_o    (acc_we_o),
  .pc_o        (pc_o),
  .ar_o        (ar_o),
  .ir_o        (ir_o),
  .step_o      (step_o),
  .regop_o     (regop_o)
);

// File: tb/tb_acs_ctrl.sv
`timescale 1ns/1ps
module tb_acs_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, halt;
  logic [15:0] ac, rdata_q;
  logic [11:0] mem_addr, pc, ar;
  logic        mem_rd, mem_wr, acc_we, regop, regop_ind;
  logic [15:0] mem_wdata, ir, dr;
  logic [1:0]  acc_op;
  logic [3:0]  step;

  logic [15:0] mem     [0:4095];
  logic [15:0] ref_mem [0:4095];

  int n_chk = 0, n_fail = 0, regop_cnt = 0, wr_cnt = 0;
  bit regop_last, done = 0;

  always #2 clk = ~clk;

  acs_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .acc_i(ac), .mem_rdata_i(rdata_q),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .acc_we_o(acc_we), .acc_op_o(acc_op), .pc_o(pc), .ar_o(ar), .ir_o(ir), .dr_o(dr),
    .step_o(step), .regop_o(regop), .regop_ind_o(regop_ind)
  );

  // memory and accumulator environment
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) rdata_q <= mem[mem_addr];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ac <= 16'h0;
    else if (acc_we) begin
      case (acc_op)
        2'd0:    ac <= ac & rdata_q;
        2'd1:    ac <= ac + rdata_q;
        default: ac <= rdata_q;
      endcase
    end
  end

  always @(negedge clk) begin
    if (regop) begin regop_cnt++; regop_last = regop_ind; end
    if (mem_wr) wr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  // run one instruction from step 0 and compare against the instruction-level model
  task automatic run_instr();
    logic [11:0] pc0, a, ea, exp_pc, wa;
    logic [15:0] w, ptr, exp_ac, wv;
    logic [2:0]  op;
    bit          ind, wr_exp;
    int          exp_cyc, cnt, rc0, wc0;
    string       req;
    pc0 = pc;
    w = ref_mem[pc0];
    ind = w[15]; op = w[14:12]; a = w[11:0];
    ptr = ref_mem[a];
    ea = ind ? ptr[11:0] : a;
    exp_pc = pc0 + 12'd1; exp_ac = ac; wr_exp = 0; wa = ea; wv = 16'h0;
    case (op)
      3'd0: begin exp_ac = ac & ref_mem[ea]; exp_cyc = 5; req = "R6"; end
      3'd1: begin exp_ac = ac + ref_mem[ea]; exp_cyc = 5; req = "R6"; end
      3'd2: begin exp_ac = ref_mem[ea];      exp_cyc = 5; req = "R6"; end
      3'd3: begin wr_exp = 1; wv = ac; exp_cyc = 4; req = "R7"; end
      3'd4: begin exp_pc = ea; exp_cyc = 4; req = "R8"; end
      3'd5: begin wr_exp = 1; wv = {4'h0, pc0 + 12'd1}; exp_pc = ea + 12'd1; exp_cyc = 4; req = "R9"; end
      3'd6: begin
        wr_exp = 1; wv = ref_mem[ea] + 16'd1; exp_cyc = 6; req = "R10";
        if (wv == 16'h0) exp_pc = pc0 + 12'd2;
      end
      default: begin exp_cyc = 4; req = "R11"; end
    endcase
    if (op != 3'd7 && ind) exp_cyc += 2;
    if (wr_exp) ref_mem[wa] = wv;
    rc0 = regop_cnt; wc0 = wr_cnt; cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (step != 4'd0 && cnt < 20);
    chk(cnt == exp_cyc, ind && op != 3'd7 ? "R5" : req, "step count", cnt, exp_cyc);
    chk(pc == exp_pc, req, "pc", pc, exp_pc);
    chk(ir == w, "R3", "ir", ir, w);
    chk(ac == exp_ac, req, "acc", ac, exp_ac);
    chk(wr_cnt - wc0 == int'(wr_exp), req, "write count", wr_cnt - wc0, wr_exp);
    if (op == 3'd7) begin
      chk(ar == a, "R4", "ar", ar, a);
      chk(regop_cnt - rc0 == 1, "R11", "handoff pulses", regop_cnt - rc0, 1);
      chk(regop_last == ind, "R11", "handoff mode", regop_last, ind);
    end else begin
      chk(ar == ea, ind ? "R5" : "R4", "ar", ar, ea);
      chk(regop_cnt == rc0, "R11", "handoff pulses", regop_cnt - rc0, 0);
      if (wr_exp) chk(mem[wa] == wv, req, "mem word", mem[wa], wv);
      if (op == 3'd6) chk(dr == wv, "R10", "dr", dr, wv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int seed_v;
    logic [11:0] pc0;
    bit quiet;
    seed_v = $urandom(32'h5EED1);
    for (int i = 0; i < 4096; i++) put(12'(i), 16'($urandom));
    rst_n = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    chk(pc == 12'h0 && ar == 12'h0, "R1", "pc/ar reset", {pc, ar}, 0);
    chk(ir == 16'h0 && dr == 16'h0, "R1", "ir/dr reset", {ir, dr}, 0);
    chk(step == 4'h0, "R1", "step reset", step, 0);
    rst_n = 1'b1;

    // directed program
    put(12'h000, 16'h2100); put(12'h100, 16'h00F0);
    put(12'h001, 16'h0101); put(12'h101, 16'h0F3C);
    put(12'h002, 16'h9102); put(12'h102, 16'hF200); put(12'h200, 16'h1234);
    put(12'h003, 16'hB103); put(12'h103, 16'hA300);
    put(12'h004, 16'h6104); put(12'h104, 16'hFFFF);
    put(12'h006, 16'hE105); put(12'h105, 16'h0305); put(12'h305, 16'h0010);
    put(12'h007, 16'h7800);
    put(12'h008, 16'hF400);
    put(12'h009, 16'h5400);
    put(12'h401, 16'hC106); put(12'h106, 16'h7020);
    for (int i = 0; i < 10; i++) run_instr();
    chk(pc == 12'h020, "R8", "indirect jump target", pc, 12'h020);

    // halt in the middle of a direct load
    put(12'h020, 16'h2107); put(12'h107, 16'h5A5A);
    pc0 = pc;
    repeat (3) @(negedge clk);
    halt = 1'b1;
    quiet = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || acc_we || regop) quiet = 0;
      chk(step == 4'd3, "R12", "frozen step", step, 3);
      chk(pc == pc0 + 12'd1, "R12", "frozen pc", pc, pc0 + 12'd1);
    end
    chk(quiet, "R12", "strobes while halted", quiet, 1);
    halt = 1'b0;
    for (int i = 0; i < 10 && step != 4'd0; i++) @(negedge clk);
    chk(ac == 16'h5A5A, "R12", "acc after resume", ac, 16'h5A5A);
    chk(step == 4'd0, "R12", "step after resume", step, 0);

    // PC wrap at the top of memory
    put(12'h021, 16'h4FFF);
    put(12'hFFF, 16'h2108); put(12'h108, 16'h0001);
    run_instr();
    run_instr();
    chk(pc == 12'h000, "R3", "pc wrap", pc, 0);

    // constrained random instructions
    for (int i = 0; i < 400; i++) begin
      if (i % 5 == 0) begin
        logic [15:0] w;
        logic [15:0] p;
        w = 16'($urandom);
        if (i % 10 == 0) w[14:12] = 3'd6;
        put(pc, w);
        if (w[14:12] == 3'd6) begin
          p = ref_mem[w[11:0]];
          put(w[15] ? p[11:0] : w[11:0], 16'hFFFF);
        end
      end
      run_instr();
    end
    finish_up();
  end
endmodule